// File: doc/BRIEF.md
# Register Block Segmenter

This block sits on the master side of a register-style management link. It accepts one request to read or write a long run of bytes in a target register and cuts the run into a chain of block transfers. The request gives a command byte that selects the register, a 16-bit starting offset into that register's space, a total byte count and a byte stream carrying the data. Each block the segmenter emits starts with the 16-bit offset at which its data lands, followed by its share of the data. The bus bit engine and the packet error code are handled elsewhere.

How large a block may be comes from the buffer-size value the target reports in its capability register. That value is sampled when a request is accepted and forced into the legal range. A value of zero selects the standard 32-byte block. Every block carries a packet number that counts down to zero, so the receiver knows how many blocks are still to come. Bytes leave on a valid/ready stream. The command, the block length and the packet number are held steady on side outputs for the whole of each block.

Top module: `blkseg_top`

## Requirements
- R1: A nonzero capability value below 3 gives an effective block length of 3, and a value above 255 gives 255. In both cases `cap_clamped` reads 1 from the cycle after acceptance until the next request is accepted; a value from 3 to 255 is used as it is and leaves `cap_clamped` at 0.
- R2: A capability value of 0 selects a block length of 32 and leaves `cap_clamped` at 0.
- R3: With effective block length E, every block carries min(remaining, E-2) data bytes, so only the last block can be short. `out_blen` equals 2 plus the block's data count, and `out_eof` marks its final byte.
- R4: Each block sends the offset low byte first, with `out_sof` set, then the offset high byte, then its data bytes in stream order.
- R5: The first block's `out_pkt` is the block count minus one, each following block's number is one lower, and the last block is numbered 0.
- R6: Each block's offset equals the request offset plus the data bytes sent in earlier blocks of the message, modulo 2^16.
- R7: `out_cmd` equals the accepted command byte in every block of the message.
- R8: A request with a length of zero produces a single block holding only the two offset bytes, with `out_blen` 2 and `out_pkt` 0.
- R9: While `out_valid` is high and `out_ready` is low, the byte and the flags are held. No input byte is consumed unless the output accepts it.
- R10: `req_ready` is low from the cycle after acceptance until the edge on which the last byte of block 0 is accepted, and is high again in the next cycle.
- R11: After reset, `req_ready` is 1, `out_valid` is 0 and `cap_clamped` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Segmenter idle, request taken on this edge |
| req_cmd | input | 8 | Register-select command byte |
| req_offset | input | 16 | Starting offset within the register |
| req_len | input | LEN_W | Total data bytes in the message |
| cap_size | input | CAP_W | Buffer-size value from the target capability register |
| cap_clamped | output | 1 | Capability value of the current message was out of range |
| in_valid | input | 1 | Data byte present |
| in_ready | output | 1 | Data byte consumed on this edge |
| in_data | input | 8 | Data byte |
| out_valid | output | 1 | Block byte present |
| out_ready | input | 1 | Block byte taken on this edge |
| out_data | output | 8 | Block byte (offset bytes then data) |
| out_sof | output | 1 | First byte of a block |
| out_eof | output | 1 | Last byte of a block |
| out_cmd | output | 8 | Command byte of the current block |
| out_blen | output | 8 | Block byte count (offset plus data) |
| out_pkt | output | LEN_W | Count-down packet number of the current block |

## Verification
The first offset byte of a message shows on `out_data` in the cycle after the edge that accepts the request, and `cap_clamped` takes its new value in that same cycle. Each later byte shows in the cycle after the edge on which the previous one was taken. `req_ready` returns one cycle after the final byte of block 0 is taken. The bench changes inputs just after rising edges and samples at falling edges. It compares a handshake seen at a falling edge with the next queued expected byte, because that byte is consumed at the rising edge that follows. Flags and `req_ready` are checked only once the queue has drained.

// File: rtl/blkseg_pkg.sv
package blkseg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OFLO = 2'd1,
    ST_OFHI = 2'd2,
    ST_DATA = 2'd3
  } seg_st_t;

  // number of blocks for a message of len bytes at d data bytes per block
  function automatic logic [31:0] seg_total(input logic [31:0] len, input logic [31:0] d);
    if (len == 32'd0) return 32'd1;
    return (len + d - 32'd1) / d;
  endfunction

  // data bytes that fit in the next block
  function automatic logic [31:0] chunk_of(input logic [31:0] remain, input logic [31:0] d);
    return (remain < d) ? remain : d;
  endfunction

endpackage

// File: rtl/blkseg_cap.sv
module blkseg_cap #(
  parameter int CAP_W   = 16,
  parameter int DEF_BLK = 32,
  parameter int MIN_BLK = 3,
  parameter int MAX_BLK = 255
) (
  input  logic [CAP_W-1:0] cap_in,
  output logic [7:0]       blk_eff,
  output logic             clamp_hit
);
  localparam logic [CAP_W-1:0] MIN_C = CAP_W'(MIN_BLK);
  localparam logic [CAP_W-1:0] MAX_C = CAP_W'(MAX_BLK);

  always_comb begin
    blk_eff   = cap_in[7:0];
    clamp_hit = 1'b0;
    if (cap_in == '0) begin
      blk_eff = 8'(DEF_BLK);
    end else if (cap_in < MIN_C) begin
      blk_eff   = 8'(MIN_BLK);
      clamp_hit = 1'b1;
    end else if (cap_in > MAX_C) begin
      blk_eff   = 8'(MAX_BLK);
      clamp_hit = 1'b1;
    end
  end
endmodule

// File: rtl/blkseg_fsm.sv
module blkseg_fsm #(
  parameter int LEN_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [7:0]            req_cmd,
  input  logic [15:0]           req_offset,
  input  logic [LEN_W-1:0]      req_len,
  input  logic [7:0]            blk_eff,
  input  logic                  clamp_hit,
  input  logic                  in_valid,
  input  logic                  out_ready,
  output blkseg_pkg::seg_st_t   st,
  output logic [15:0]           cur_off,
  output logic [LEN_W-1:0]      chunk,
  output logic [LEN_W-1:0]      pkt_q,
  output logic [7:0]            cmd_q,
  output logic                  clamp_q,
  output logic                  out_valid,
  output logic                  last_byte,
  output logic                  seg_done,
  output logic                  msg_done,
  output logic                  in_ready,
  output logic                  req_ready
);
  import blkseg_pkg::*;

  logic [LEN_W-1:0] remain;
  logic [LEN_W-1:0] bcnt;
  logic [7:0]       dsz_q;
  logic [7:0]       dsz_new;
  logic [LEN_W-1:0] total_new;
  logic             fire;

  assign dsz_new   = blk_eff - 8'd2;
  assign total_new = LEN_W'(seg_total(32'(req_len), 32'(dsz_new)));
  assign chunk     = LEN_W'(chunk_of(32'(remain), 32'(dsz_q)));

  assign req_ready = (st == ST_IDLE);
  assign out_valid = (st == ST_OFLO) || (st == ST_OFHI) || ((st == ST_DATA) && in_valid);
  assign in_ready  = (st == ST_DATA) && out_ready;
  assign fire      = out_valid && out_ready;
  assign last_byte = ((st == ST_OFHI) && (chunk == '0)) ||
                     ((st == ST_DATA) && (bcnt == chunk - LEN_W'(1)));
  assign seg_done  = fire && last_byte;
  assign msg_done  = seg_done && (pkt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      remain  <= '0;
      bcnt    <= '0;
      dsz_q   <= 8'd1;
      cur_off <= '0;
      pkt_q   <= '0;
      cmd_q   <= '0;
      clamp_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          cmd_q   <= req_cmd;
          cur_off <= req_offset;
          remain  <= req_len;
          dsz_q   <= dsz_new;
          pkt_q   <= total_new - LEN_W'(1);
          clamp_q <= clamp_hit;
          st      <= ST_OFLO;
        end
        ST_OFLO: if (fire) st <= ST_OFHI;
        ST_OFHI: if (fire && !last_byte) begin
          bcnt <= '0;
          st   <= ST_DATA;
        end
        ST_DATA: if (fire && !last_byte) bcnt <= bcnt + LEN_W'(1);
        default: st <= ST_IDLE;
      endcase
      if (seg_done) begin
        remain  <= remain - chunk;
        cur_off <= cur_off + 16'(chunk);
        if (pkt_q == '0) begin
          st <= ST_IDLE;
        end else begin
          pkt_q <= pkt_q - LEN_W'(1);
          st    <= ST_OFLO;
        end
      end
    end
  end
endmodule

// File: rtl/blkseg_mux.sv
module blkseg_mux (
  input  blkseg_pkg::seg_st_t st,
  input  logic [15:0]         cur_off,
  input  logic [7:0]          in_data,
  input  logic [7:0]          chunk_lo,
  input  logic                last_byte,
  output logic [7:0]          out_data,
  output logic                out_sof,
  output logic                out_eof,
  output logic [7:0]          out_blen
);
  import blkseg_pkg::*;

  always_comb begin
    unique case (st)
      ST_OFLO: out_data = cur_off[7:0];
      ST_OFHI: out_data = cur_off[15:8];
      default: out_data = in_data;
    endcase
  end

  assign out_sof  = (st == ST_OFLO);
  assign out_eof  = last_byte;
  assign out_blen = chunk_lo + 8'd2;
endmodule

// File: rtl/blkseg_top.sv
module blkseg_top #(
  parameter int LEN_W   = 16,
  parameter int CAP_W   = 16,
  parameter int DEF_BLK = 32,
  parameter int MIN_BLK = 3,
  parameter int MAX_BLK = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [7:0]       req_cmd,
  input  logic [15:0]      req_offset,
  input  logic [LEN_W-1:0] req_len,
  input  logic [CAP_W-1:0] cap_size,
  output logic             cap_clamped,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic             out_eof,
  output logic [7:0]       out_cmd,
  output logic [7:0]       out_blen,
  output logic [LEN_W-1:0] out_pkt
);
  import blkseg_pkg::*;

  logic [7:0]       blk_eff;
  logic             clamp_hit;
  seg_st_t          st;
  logic [15:0]      cur_off;
  logic [LEN_W-1:0] chunk;
  logic             last_byte;
  logic             seg_done;
  logic             msg_done;

  blkseg_cap #(.CAP_W(CAP_W), .DEF_BLK(DEF_BLK), .MIN_BLK(MIN_BLK), .MAX_BLK(MAX_BLK)) u_cap (
    .cap_in   (cap_size),
    .blk_eff  (blk_eff),
    .clamp_hit(clamp_hit)
  );

  blkseg_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_cmd   (req_cmd),
    .req_offset(req_offset),
    .req_len   (req_len),
    .blk_eff   (blk_eff),
    .clamp_hit (clamp_hit),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .st        (st),
    .cur_off   (cur_off),
    .chunk     (chunk),
    .pkt_q     (out_pkt),
    .cmd_q     (out_cmd),
    .clamp_q   (cap_clamped),
    .out_valid (out_valid),
    .last_byte (last_byte),
    .seg_done  (seg_done),
    .msg_done  (msg_done),
    .in_ready  (in_ready),
    .req_ready (req_ready)
  );

  blkseg_mux u_mux (
    .st       (st),
    .cur_off  (cur_off),
    .in_data  (in_data),
    .chunk_lo (chunk[7:0]),
    .last_byte(last_byte),
    .out_data (out_data),
    .out_sof  (out_sof),
    .out_eof  (out_eof),
    .out_blen (out_blen)
  );
endmodule

// File: rtl/blkseg_chk.sv
module blkseg_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_sof,
  input logic             out_eof,
  input logic [7:0]       out_blen,
  input logic [LEN_W-1:0] out_pkt,
  input logic             req_ready,
  input logic             in_ready,
  input logic             seg_done,
  input logic             msg_done
);
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof)); // R9

  AST_NO_TAKE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> !in_ready); // R9

  AST_BLEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_blen >= 8'd2) && (out_blen <= 8'd255)); // R3

  AST_PKT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    seg_done && !msg_done |=> out_pkt == $past(out_pkt) - LEN_W'(1)); // R5

  AST_NEXT_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    seg_done && !msg_done |=> out_valid && out_sof); // R4

  AST_IDLE_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |=> req_ready && !out_valid); // R10

  AST_SOF_NOT_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sof |-> !out_eof); // R4
endmodule

bind blkseg_top blkseg_chk #(.LEN_W(LEN_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .out_sof  (out_sof),
  .out_eof  (out_eof),
  .out_blen (out_blen),
  .out_pkt  (out_pkt),
  .req_ready(req_ready),
  .in_ready (in_ready),
  .seg_done (seg_done),
  .msg_done (msg_done)
);

// File: tb/blkseg_top_tb.sv
module blkseg_top_tb;
  localparam int LEN_W = 16;
  localparam int CAP_W = 16;

  typedef struct {
    logic [7:0]       data;
    logic             sof;
    logic             eof;
    logic [7:0]       blen;
    logic [LEN_W-1:0] pkt;
    logic [7:0]       cmd;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [7:0] req_cmd = '0;
  logic [15:0] req_offset = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [CAP_W-1:0] cap_size = '0;
  logic cap_clamped;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [7:0] out_data;
  logic out_sof, out_eof;
  logic [7:0] out_cmd, out_blen;
  logic [LEN_W-1:0] out_pkt;

  int total = 0;
  int bad = 0;
  bit in_stall = 0;
  bit out_stall = 0;
  exp_t exp_q[$];
  logic [7:0] data_q[$];

  always #4 clk = ~clk;

  blkseg_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
    .req_offset(req_offset), .req_len(req_len), .cap_size(cap_size),
    .cap_clamped(cap_clamped),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .out_cmd(out_cmd),
    .out_blen(out_blen), .out_pkt(out_pkt)
  );

  task automatic check(input bit ok, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  // monitor: a handshake seen at the falling edge is consumed at the next rising edge
  initial forever begin
    @(negedge clk);
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "R3 unexpected output byte", int'(out_data), -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(out_data == e.data, "R4 R6 byte value", int'(out_data), int'(e.data));
        check(out_sof == e.sof, "R4 sof flag", int'(out_sof), int'(e.sof));
        check(out_eof == e.eof, "R3 eof flag", int'(out_eof), int'(e.eof));
        check(out_blen == e.blen, "R3 block length", int'(out_blen), int'(e.blen));
        check(out_pkt == e.pkt, "R5 packet number", int'(out_pkt), int'(e.pkt));
        check(out_cmd == e.cmd, "R7 command", int'(out_cmd), int'(e.cmd));
      end
    end
  end

  // data feeder: holds in_valid until the byte is taken
  initial begin
    int n = 0;
    bit took;
    forever begin
      @(negedge clk);
      took = in_valid && in_ready;
      @(posedge clk);
      #1;
      n++;
      if (took) void'(data_q.pop_front());
      if (took || !in_valid) begin
        if (data_q.size() > 0 && !(in_stall && (n % 3 == 0))) begin
          in_valid = 1'b1;
          in_data  = data_q[0];
        end else begin
          in_valid = 1'b0;
        end
      end
    end
  end

  // output back-pressure pattern
  initial begin
    int n = 0;
    forever begin
      @(posedge clk);
      #1;
      n++;
      out_ready = !(out_stall && (n % 4 == 1));
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic send_msg(input logic [7:0] cmd, input logic [15:0] off,
                          input int len, input int cap, input logic [7:0] base);
    int eff, d, nseg, rem, ch, k;
    logic [15:0] o;
    bit clamp;
    // expected block size restated from R1 and R2
    clamp = 0;
    if (cap == 0) eff = 32;
    else if (cap < 3) begin eff = 3; clamp = 1; end
    else if (cap > 255) begin eff = 255; clamp = 1; end
    else eff = cap;
    d = eff - 2;
    nseg = 0; rem = len;
    do begin nseg++; rem -= (rem < d) ? rem : d; end while (rem > 0);
    rem = len; o = off; k = 0;
    for (int s = 0; s < nseg; s++) begin
      ch = (rem < d) ? rem : d;
      exp_q.push_back('{o[7:0], 1'b1, 1'b0, 8'(ch + 2), LEN_W'(nseg - 1 - s), cmd});
      exp_q.push_back('{o[15:8], 1'b0, ch == 0, 8'(ch + 2), LEN_W'(nseg - 1 - s), cmd});
      for (int i = 0; i < ch; i++) begin
        exp_q.push_back('{8'(base + k), 1'b0, i == ch - 1, 8'(ch + 2), LEN_W'(nseg - 1 - s), cmd});
        k++;
      end
      o = o + 16'(ch);
      rem -= ch;
    end
    for (int i = 0; i < len; i++) data_q.push_back(8'(base + i));
    @(posedge clk); #1;
    req_cmd = cmd; req_offset = off; req_len = LEN_W'(len); cap_size = CAP_W'(cap);
    req_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b0, "R10 busy after accept", int'(req_ready), 0);
    check(cap_clamped == clamp, "R1 R2 clamp flag", int'(cap_clamped), int'(clamp));
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    check(req_ready == 1'b1, "R10 ready after last block", int'(req_ready), 1);
    check(out_valid == 1'b0, "R10 output idle", int'(out_valid), 0);
    check(data_q.size() == 0, "R9 all input consumed", data_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    check(req_ready == 1'b1, "R11 req_ready", int'(req_ready), 1);
    check(out_valid == 1'b0, "R11 out_valid", int'(out_valid), 0);
    check(cap_clamped == 1'b0, "R11 cap_clamped", int'(cap_clamped), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    send_msg(8'h21, 16'h0100, 60, 32, 8'h10);   // R3 R5 R6: 30+30 data
    send_msg(8'h22, 16'h0000, 31, 32, 8'h40);   // R3: 30+1 short tail
    send_msg(8'h23, 16'h0010, 70, 0, 8'h80);    // R2 default 32
    send_msg(8'h24, 16'hFFFE, 5, 2, 8'h05);     // R1 clamp low, R6 offset wrap
    send_msg(8'h25, 16'h1234, 600, 300, 8'h00); // R1 clamp high: 253,253,94
    send_msg(8'h26, 16'hABCD, 0, 32, 8'h00);    // R8 empty message
    send_msg(8'h27, 16'h0020, 17, 10, 8'h33);   // R1 in range, no flag
    in_stall = 1; out_stall = 1;
    send_msg(8'h28, 16'h0200, 45, 16, 8'h60);   // R9 back-pressure on both sides
    send_msg(8'h29, 16'h0000, 1, 3, 8'h77);     // R9 R3 one byte per block
    in_stall = 0; out_stall = 0;
    send_msg(8'h2A, 16'h0300, 1, 0, 8'hF0);     // R5 single block numbered 0
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule